// File: doc/BRIEF.md
# Legacy I/O Configuration Unlock Decoder

This block holds the configuration state of a legacy PC peripheral combo device. It sits on a byte-wide I/O bus at two adjacent addresses. The lower address is the index port and the upper address is the data port. Configuration access is locked after reset. The host opens it by writing the key byte 0x55 twice in a row to the index port. It closes it again by writing 0xAA to the index port.

While configuration access is open, an index-port write selects one of sixteen 8-bit registers, and the data port reads or writes the selected register. The block decodes the register contents continuously into several outputs:
- enables, base addresses and fixed interrupt line numbers for two serial ports;
- the enable and base address of one parallel port;
- three floppy control fields.

The serial base addresses can come from a shared table of alternate address pairs. Other register bits pick the pair in use.

Top module: `lcd_top`

## Requirements
- R1: While rst_ni is low, the key history is cleared, the index is set to 0, and the registers take their defaults: 0x3B at 0, 0x9F at 1, 0xDC at 2, 0x78 at 3, 0xFF at 6, 0x65 at 13 and 0x01 at 14, with zero in every other register. These defaults decode to serial A enabled at 0x3F8, serial B enabled at 0x2F8, the parallel port enabled at 0x278, and all floppy outputs at 0.
- R2: The block keeps the last two bytes pushed by index-port writes. Configuration mode (cfg_mode_o=1) holds exactly when both bytes equal 0x55. Outside configuration mode, every index-port write is pushed. cfg_mode_o changes in the cycle after the write edge.
- R3: In configuration mode, an index-port write of 0xAA is pushed and so ends configuration mode. A single 0x55 afterwards does not reopen it; a second 0x55 does.
- R4: In configuration mode, an index-port write of any value other than 0xAA sets the index to bits 3:0 of that value and leaves the history unchanged. A write of 0x55 therefore selects register 5 and keeps configuration mode.
- R5: Outside configuration mode, data-port writes change no register, and data-port reads return 0xFF.
- R6: In configuration mode, a data-port read (rd_i=1, addr_i=0x3F1) returns the register at the current index in the same cycle. Reads have no side effects. A data-port write updates the indexed register and the decoded outputs in the cycle after the write edge.
- R7: Register 1 bits 6:5 select the alternate serial address pair (ALT0/ALT1): 00 gives 0x338/0x238, 01 gives 0x3E8/0x2E8, 10 gives 0x3E8/0x2E0, 11 gives 0x220/0x228.
- R8: Serial A is enabled by register 2 bit 2. Its base comes from register 2 bits 1:0: 0 gives 0x3F8, 1 gives 0x2F8, 2 gives ALT0, 3 gives ALT1. Its interrupt line output is 4.
- R9: Serial B is enabled by register 2 bit 6. Its base comes from register 2 bits 5:4, using the same four choices as serial A. Its interrupt line output is 3.
- R10: Register 1 bits 1:0 select the parallel port: 0 disables it and sets the base to 0, 1 gives 0x3BC, 2 gives 0x378, 3 gives 0x278.
- R11: fdc_enh_o equals register 3 bit 1, dens_force_o equals register 5 bits 4:3, and drive_swap_o equals register 5 bit 5.
- R12: The port decode compares all 16 address bits. Writes or reads at any address other than 0x3F0 and 0x3F1 have no effect, and such a read returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | I/O address |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0xFF when not a valid configuration read |
| cfg_mode_o | output | 1 | Configuration mode active |
| ser_a_en_o | output | 1 | Serial A enable |
| ser_a_base_o | output | 16 | Serial A base address |
| ser_a_irq_o | output | 4 | Serial A interrupt line number |
| ser_b_en_o | output | 1 | Serial B enable |
| ser_b_base_o | output | 16 | Serial B base address |
| ser_b_irq_o | output | 4 | Serial B interrupt line number |
| par_en_o | output | 1 | Parallel port enable |
| par_base_o | output | 16 | Parallel port base address |
| fdc_enh_o | output | 1 | Enhanced floppy mode flag |
| dens_force_o | output | 2 | Density-select force code |
| drive_swap_o | output | 1 | Drive swap flag |

## Verification
The hardest state to reach is an index-port write of 0x55 made while configuration mode is already open. From outside, this looks like a key byte, but it must act as a register selection (register 5) rather than a history push. The stimulus reaches it in three steps:
1. Unlock through an interrupted key sequence (0x55, 0x12, 0x55, 0x55), so that a non-key byte sits between the keys.
2. Issue the 0x55 index write while unlocked.
3. Write register 5 and watch the floppy outputs.

A behavioural model built on a byte queue runs alongside the design and tracks the history, index and registers. The same run also covers the relock sequence and full-address aliases such as 0x13F0.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int NREG     = 16;
  localparam int IDX_W    = $clog2(NREG);
  localparam int KEY_LEN  = 2;
  localparam int IRQ_W    = 4;
  localparam int NSER     = 2;

  localparam logic [DATA_W-1:0] KEY_OPEN  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_CLOSE = 8'hAA;
  localparam logic [ADDR_W-1:0] IDX_PORT  = 16'h03F0;
  localparam logic [ADDR_W-1:0] DAT_PORT  = 16'h03F1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef struct packed {
    addr_t alt0;
    addr_t alt1;
  } alt_pair_t;

  function automatic byte_t reg_default(input int i);
    case (i)
      0:       return 8'h3B;
      1:       return 8'h9F;
      2:       return 8'hDC;
      3:       return 8'h78;
      6:       return 8'hFF;
      13:      return 8'h65;
      14:      return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic alt_pair_t alt_pair(input logic [1:0] sel);
    case (sel)
      2'd0:    return '{alt0: 16'h0338, alt1: 16'h0238};
      2'd1:    return '{alt0: 16'h03E8, alt1: 16'h02E8};
      2'd2:    return '{alt0: 16'h03E8, alt1: 16'h02E0};
      default: return '{alt0: 16'h0220, alt1: 16'h0228};
    endcase
  endfunction
endpackage

// File: rtl/lcd_key_tracker.sv
module lcd_key_tracker
  import lcd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idx_wr_i,
  input  byte_t            wdata_i,
  output logic             cfg_o,
  output logic [IDX_W-1:0] idx_o
);
  byte_t            hist_q [KEY_LEN];
  logic [IDX_W-1:0] idx_q;
  logic             push;
  logic             match;

  always_comb begin
    match = 1'b1;
    for (int i = 0; i < KEY_LEN; i++) match = match & (hist_q[i] == KEY_OPEN);
  end

  assign push = idx_wr_i && (!match || wdata_i == KEY_CLOSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < KEY_LEN; i++) hist_q[i] <= '0;
      idx_q <= '0;
    end else if (push) begin
      for (int i = 0; i < KEY_LEN - 1; i++) hist_q[i] <= hist_q[i+1];
      hist_q[KEY_LEN-1] <= wdata_i;
    end else if (idx_wr_i) begin
      idx_q <= wdata_i[IDX_W-1:0];
    end
  end

  assign cfg_o = match;
  assign idx_o = idx_q;

  // R2
  key_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_o) |-> $past(idx_wr_i && wdata_i == KEY_OPEN));

  // R3
  key_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o && idx_wr_i && wdata_i == KEY_CLOSE) |=> !cfg_o);

  // R4
  idx_keep_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o && idx_wr_i && wdata_i != KEY_CLOSE) |=> (cfg_o && idx_o == $past(wdata_i[IDX_W-1:0])));
endmodule

// File: rtl/lcd_reg_file.sv
module lcd_reg_file
  import lcd_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  byte_t                  wdata_i,
  output logic [NREG-1:0][DATA_W-1:0] regs_o
);
  logic [NREG-1:0][DATA_W-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= reg_default(i);
    end else if (we_i) begin
      regs_q[idx_i] <= wdata_i;
    end
  end

  assign regs_o = regs_q;

  // R6
  reg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_o[$past(idx_i)] == $past(wdata_i));
endmodule

// File: rtl/lcd_port_decode.sv
module lcd_port_decode
  import lcd_pkg::*;
(
  input  logic [1:0]              alt_sel_i,
  input  logic [NSER-1:0]         ser_en_i,
  input  logic [NSER-1:0][1:0]    ser_sel_i,
  input  logic [1:0]              par_sel_i,
  output logic [NSER-1:0]         ser_en_o,
  output logic [NSER-1:0][ADDR_W-1:0] ser_base_o,
  output logic [NSER-1:0][IRQ_W-1:0]  ser_irq_o,
  output logic                    par_en_o,
  output addr_t                   par_base_o
);
  alt_pair_t pair;
  assign pair = alt_pair(alt_sel_i);

  for (genvar g = 0; g < NSER; g++) begin : g_ser
    localparam logic [IRQ_W-1:0] IRQ_LINE = (g == 0) ? IRQ_W'(4) : IRQ_W'(3);
    always_comb begin
      case (ser_sel_i[g])
        2'd0:    ser_base_o[g] = 16'h03F8;
        2'd1:    ser_base_o[g] = 16'h02F8;
        2'd2:    ser_base_o[g] = pair.alt0;
        default: ser_base_o[g] = pair.alt1;
      endcase
    end
    assign ser_en_o[g]  = ser_en_i[g];
    assign ser_irq_o[g] = IRQ_LINE;
  end

  always_comb begin
    case (par_sel_i)
      2'd1:    par_base_o = 16'h03BC;
      2'd2:    par_base_o = 16'h0378;
      2'd3:    par_base_o = 16'h0278;
      default: par_base_o = 16'h0000;
    endcase
  end
  assign par_en_o = par_sel_i != 2'd0;

  // R10
  always_comb par_off_chk: assert (par_en_o || par_base_o == 16'h0000);
endmodule

// File: rtl/lcd_top.sv
module lcd_top
  import lcd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        cfg_mode_o,
  output logic        ser_a_en_o,
  output logic [15:0] ser_a_base_o,
  output logic [3:0]  ser_a_irq_o,
  output logic        ser_b_en_o,
  output logic [15:0] ser_b_base_o,
  output logic [3:0]  ser_b_irq_o,
  output logic        par_en_o,
  output logic [15:0] par_base_o,
  output logic        fdc_enh_o,
  output logic [1:0]  dens_force_o,
  output logic        drive_swap_o
);
  logic                        hit_idx, hit_dat, cfg;
  logic [IDX_W-1:0]            idx;
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [NSER-1:0]             ser_en_in, ser_en;
  logic [NSER-1:0][1:0]        ser_sel;
  logic [NSER-1:0][ADDR_W-1:0] ser_base;
  logic [NSER-1:0][IRQ_W-1:0]  ser_irq;

  assign hit_idx = addr_i == IDX_PORT;
  assign hit_dat = addr_i == DAT_PORT;

  lcd_key_tracker u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_wr_i (wr_i && hit_idx),
    .wdata_i  (wdata_i),
    .cfg_o    (cfg),
    .idx_o    (idx)
  );

  lcd_reg_file u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i && hit_dat && cfg),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .regs_o  (regs)
  );

  assign ser_en_in  = {regs[2][6], regs[2][2]};
  assign ser_sel[0] = regs[2][1:0];
  assign ser_sel[1] = regs[2][5:4];

  lcd_port_decode u_dec (
    .alt_sel_i  (regs[1][6:5]),
    .ser_en_i   (ser_en_in),
    .ser_sel_i  (ser_sel),
    .par_sel_i  (regs[1][1:0]),
    .ser_en_o   (ser_en),
    .ser_base_o (ser_base),
    .ser_irq_o  (ser_irq),
    .par_en_o   (par_en_o),
    .par_base_o (par_base_o)
  );

  assign rdata_o      = (rd_i && hit_dat && cfg) ? regs[idx] : 8'hFF;
  assign cfg_mode_o   = cfg;
  assign ser_a_en_o   = ser_en[0];
  assign ser_a_base_o = ser_base[0];
  assign ser_a_irq_o  = ser_irq[0];
  assign ser_b_en_o   = ser_en[1];
  assign ser_b_base_o = ser_base[1];
  assign ser_b_irq_o  = ser_irq[1];
  assign fdc_enh_o    = regs[3][1];
  assign dens_force_o = regs[5][4:3];
  assign drive_swap_o = regs[5][5];

  // R5
  locked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_o && !(wr_i && hit_idx)) |=> ($stable(regs) && !cfg_mode_o));

  // R12
  alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_idx && !hit_dat) |=> ($stable(regs) && $stable(cfg_mode_o)));
endmodule

// File: tb/lcd_top_test.sv
module lcd_top_test;
  logic        clk = 0, rst_n = 0;
  logic [15:0] addr = 0;
  logic        wr = 0, rd = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic        cfg_mode, sa_en, sb_en, p_en, enh, swp;
  logic [15:0] sa_base, sb_base, p_base;
  logic [3:0]  sa_irq, sb_irq;
  logic [1:0]  dens;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lcd_top uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .cfg_mode_o(cfg_mode),
    .ser_a_en_o(sa_en), .ser_a_base_o(sa_base), .ser_a_irq_o(sa_irq),
    .ser_b_en_o(sb_en), .ser_b_base_o(sb_base), .ser_b_irq_o(sb_irq),
    .par_en_o(p_en), .par_base_o(p_base),
    .fdc_enh_o(enh), .dens_force_o(dens), .drive_swap_o(swp)
  );

  // reference model
  int m_hist[$];
  int m_idx;
  int m_regs[16];

  function automatic bit m_cfg();
    return m_hist[0] == 'h55 && m_hist[1] == 'h55;
  endfunction

  function automatic int m_alt(int sel, int which);
    int a0, a1;
    case (sel)
      0: begin a0 = 'h338; a1 = 'h238; end
      1: begin a0 = 'h3E8; a1 = 'h2E8; end
      2: begin a0 = 'h3E8; a1 = 'h2E0; end
      default: begin a0 = 'h220; a1 = 'h228; end
    endcase
    return which ? a1 : a0;
  endfunction

  function automatic int m_ser_base(int sel);
    int alt;
    alt = (m_regs[1] >> 5) & 3;
    case (sel)
      0: return 'h3F8;
      1: return 'h2F8;
      2: return m_alt(alt, 0);
      default: return m_alt(alt, 1);
    endcase
  endfunction

  function automatic int m_par_base();
    case (m_regs[1] & 3)
      1: return 'h3BC;
      2: return 'h378;
      3: return 'h278;
      default: return 0;
    endcase
  endfunction

  task automatic m_reset();
    m_hist = '{0, 0};
    m_idx = 0;
    foreach (m_regs[i]) m_regs[i] = 0;
    m_regs[0] = 'h3B; m_regs[1] = 'h9F; m_regs[2] = 'hDC; m_regs[3] = 'h78;
    m_regs[6] = 'hFF; m_regs[13] = 'h65; m_regs[14] = 'h01;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else if (wr && addr == 16'h03F0) begin
      if (m_cfg() && wdata != 8'hAA) m_idx = wdata & 15;
      else begin
        void'(m_hist.pop_front());
        m_hist.push_back(int'(wdata));
      end
    end else if (wr && addr == 16'h03F1 && m_cfg()) m_regs[m_idx] = wdata;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (!done) begin
    chk("R2 cfg", cfg_mode, m_cfg());
    chk("R6 rdata", rdata, (rd && addr == 16'h03F1 && m_cfg()) ? m_regs[m_idx] : 'hFF);
    chk("R8 en", sa_en, (m_regs[2] >> 2) & 1);
    chk("R8 base", sa_base, m_ser_base(m_regs[2] & 3));
    chk("R8 irq", sa_irq, 4);
    chk("R9 en", sb_en, (m_regs[2] >> 6) & 1);
    chk("R9 base", sb_base, m_ser_base((m_regs[2] >> 4) & 3));
    chk("R9 irq", sb_irq, 3);
    chk("R10 en", p_en, (m_regs[1] & 3) != 0);
    chk("R10 base", p_base, m_par_base());
    chk("R11 enh", enh, (m_regs[3] >> 1) & 1);
    chk("R11 dens", dens, (m_regs[5] >> 3) & 3);
    chk("R11 swap", swp, (m_regs[5] >> 5) & 1);
  end

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #2 addr = a; wdata = d; wr = 1;
    @(posedge clk); #2 wr = 0; addr = 0;
    @(negedge clk);
  endtask

  task automatic idx_wr(input logic [7:0] d); bus_wr(16'h03F0, d); endtask
  task automatic dat_wr(input logic [7:0] d); bus_wr(16'h03F1, d); endtask

  task automatic rd_chk(input logic [15:0] a, input int exp, input string req);
    @(posedge clk); #2 addr = a; rd = 1;
    @(negedge clk); chk(req, rdata, exp);
    @(posedge clk); #2 rd = 0; addr = 0;
  endtask

  task automatic set_reg(input int r, input logic [7:0] v);
    idx_wr(8'(r)); dat_wr(v);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg", cfg_mode, 0);
    chk("R1 sa_base", sa_base, 'h3F8);
    chk("R1 sb_base", sb_base, 'h2F8);
    chk("R1 par", p_base, 'h278);
    chk("R1 en", {sa_en, sb_en, p_en}, 3'b111);
    chk("R1 fdc", {enh, dens, swp}, 0);
    rd_chk(16'h03F1, 'hFF, "R5 locked read");
    // R5 locked write ignored
    dat_wr(8'h00);
    chk("R5 no effect", sa_base, 'h3F8);
    // R2 interrupted key sequence
    idx_wr(8'h55); idx_wr(8'h12); idx_wr(8'h55);
    chk("R2 interrupted", cfg_mode, 0);
    idx_wr(8'h55);
    chk("R2 open", cfg_mode, 1);
    rd_chk(16'h03F1, 'h3B, "R1 reg0 (R5 write lost)");
    rd_chk(16'h03F1, 'h3B, "R6 read no side effect");
    idx_wr(8'h0D); rd_chk(16'h03F1, 'h65, "R1 regD");
    idx_wr(8'hEE); rd_chk(16'h03F1, 'h01, "R4 high nibble ignored");
    idx_wr(8'h06); rd_chk(16'h03F1, 'hFF, "R1 reg6");
    // R12 aliases
    bus_wr(16'h13F0, 8'hAA);
    chk("R12 alias idx", cfg_mode, 1);
    bus_wr(16'h13F1, 8'h00);
    rd_chk(16'h03F1, 'hFF, "R12 alias data write");
    rd_chk(16'h13F1, 'hFF, "R12 alias read");
    // R4 0x55 selects reg5 in cfg
    idx_wr(8'h55);
    chk("R4 stay cfg", cfg_mode, 1);
    dat_wr(8'h38);
    chk("R11 dens", dens, 3);
    chk("R11 swap", swp, 1);
    set_reg(3, 8'h02);
    chk("R11 enh", enh, 1);
    // R7 R8 R9 R10 sweep
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 4; s++) begin
        set_reg(1, 8'((p << 5) | s));
        set_reg(2, 8'h40 | 8'h04 | 8'(s) | 8'((3 - s) << 4));
        chk("R10 sweep", p_base, s == 0 ? 0 : (s == 1 ? 'h3BC : (s == 2 ? 'h378 : 'h278)));
      end
      set_reg(2, 8'h76);
      chk("R7 alt0", sa_base, m_alt(p, 0));
      chk("R7 alt1", sb_base, m_alt(p, 1));
    end
    set_reg(2, 8'h00);
    chk("R8 disabled", sa_en, 0);
    chk("R9 disabled", sb_en, 0);
    // R3 close then reopen
    idx_wr(8'hAA);
    chk("R3 closed", cfg_mode, 0);
    rd_chk(16'h03F1, 'hFF, "R3 read locked");
    idx_wr(8'h55);
    chk("R3 single key", cfg_mode, 0);
    idx_wr(8'h55);
    chk("R3 reopen", cfg_mode, 1);
    // R1 reset mid-run
    @(posedge clk); #2 rst_n = 0;
    repeat (2) @(posedge clk); #2 rst_n = 1;
    @(negedge clk);
    chk("R1 reset again cfg", cfg_mode, 0);
    chk("R1 reset again reg2", {sa_en, sb_en}, 2'b11);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule